// File: doc/BRIEF.md
# Keyed One-Shot Watchdog Timer

This block is the watchdog of a small controller. It stays idle after a hardware reset. Software starts it by writing a two-byte key, first 0x1E and then 0xE1, to a single write-only bus address. From then on the count advances once for every machine cycle. Software must write the same key again before the count runs out. Each complete key clears the count to zero. Once the watchdog is running, no write can stop it. Only a hardware reset or its own overflow returns it to idle.

When the count runs past its largest value, the block raises an internal reset for a fixed number of oscillator (clock) cycles. For the same cycles it drives the external reset pin high. One bit in a byte written to a second, auxiliary address can hold the pin low during that pulse. The internal reset still fires. The machine-cycle enable and the bus-write port come from the surrounding controller. The block does not decode any other register.

Top module: `wdt_keyed`

## Requirements
- R1: After a hardware reset `rst`, the watchdog is idle and both `sys_rst_out` and `rst_pin_out` are low. Without a key, neither output ever rises.
- R2: A write of 0x1E followed by a write of 0xE1 to address 0xA6 arms the watchdog with its count at zero. The arming clock edge is the edge that samples the 0xE1 write.
- R3: While armed, the 14-bit count advances on every clock edge with `mc_en` high. The overflow edge is the 16384th such edge after arming, the one that finds the count at 0x3FFF. `sys_rst_out` is high from that edge on.
- R4: While `mc_en` is low, the count holds its value, so the overflow is delayed by exactly the number of cycles with the enable low.
- R5: While armed, a complete key restarts the count at zero from the edge that samples 0xE1. A repeated 0x1E before the 0xE1 still leaves the key pending.
- R6: A key broken in any of these ways does not restart the count: some other byte after 0x1E, a 0xE1 with no 0x1E pending, or a key byte sent to another address.
- R7: No bus write, including writes of arbitrary bytes to 0xA6 and 0x8E, stops an armed watchdog.
- R8: On overflow, `sys_rst_out` stays high for exactly 98 clock cycles and then falls.
- R9: A byte written to address 0x8E sets the pin-suppress flag from its bit 3. With bit 3 clear (the reset default), `rst_pin_out` follows `sys_rst_out` for the whole pulse. With bit 3 set, `rst_pin_out` stays low during the pulse.
- R10: The overflow returns the watchdog to idle, and key writes made during the pulse are ignored. No further pulse occurs without a new key after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| mc_en | input | 1 | Machine-cycle enable, one clock wide per machine cycle |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 8 | Bus write address |
| wr_data | input | 8 | Bus write data |
| rst_pin_out | output | 1 | Drive-high request for the external reset pin |
| sys_rst_out | output | 1 | Internal system reset |

## Verification
The bound assertions check on every cycle the following:
- the pin is never high without the internal reset;
- the pin level holds steady through a pulse;
- every pulse ends after exactly 98 cycles;
- the watchdog is idle during a pulse;
- a pulse only starts from the armed state.

Only the directed scenarios can show the rest:
- the exact overflow edge counted from arming or from a restart;
- the effect of gaps in `mc_en`;
- which broken key orders fail to restart;
- the effect of the suppress bit;
- the absence of a later pulse after an overflow or a hardware reset.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;
  typedef enum logic {
    KEY_IDLE = 1'b0,
    KEY_HALF = 1'b1
  } key_state_t;

  localparam int          WDT_BUS_W    = 8;
  localparam logic [7:0]  WDT_KEY_A    = 8'h1E;
  localparam logic [7:0]  WDT_KEY_B    = 8'hE1;
  localparam logic [7:0]  WDT_KEY_ADDR = 8'hA6;
  localparam logic [7:0]  WDT_AUX_ADDR = 8'h8E;
endpackage

// File: rtl/wdt_key_decoder.sv
module wdt_key_decoder
  import wdt_keyed_pkg::*;
#(
  parameter int            AW          = 8,
  parameter int            DW          = 8,
  parameter logic [AW-1:0] KEY_ADDR    = WDT_KEY_ADDR,
  parameter logic [AW-1:0] AUX_ADDR    = WDT_AUX_ADDR,
  parameter logic [DW-1:0] KEY_FIRST   = WDT_KEY_A,
  parameter logic [DW-1:0] KEY_SECOND  = WDT_KEY_B,
  parameter int            PIN_DIS_BIT = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          kick,
  output logic          pin_dis
);
  key_state_t state;
  logic       key_wr;

  assign key_wr = wr_en && (wr_addr == KEY_ADDR);
  assign kick   = key_wr && !hold && (state == KEY_HALF) && (wr_data == KEY_SECOND);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= KEY_IDLE;
      pin_dis <= 1'b0;
    end else begin
      if (wr_en && (wr_addr == AUX_ADDR))
        pin_dis <= wr_data[PIN_DIS_BIT];
      if (hold)
        state <= KEY_IDLE;
      else if (key_wr)
        state <= (wr_data == KEY_FIRST) ? KEY_HALF : KEY_IDLE;
    end
  end
endmodule

// File: rtl/wdt_cycle_counter.sv
module wdt_cycle_counter #(
  parameter int CNT_W = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic mc_en,
  input  logic kick,
  output logic armed,
  output logic overflow
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;

  assign overflow = armed && !kick && mc_en && (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (kick) begin
      armed <= 1'b1;
      cnt   <= '0;
    end else if (overflow) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (armed && mc_en) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_pulse_gen.sv
module wdt_pulse_gen #(
  parameter int LEN = 98
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic pin_dis,
  output logic sys_rst_q,
  output logic pin_q
);
  localparam int PW = (LEN > 1) ? $clog2(LEN) : 1;

  logic [PW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_rst_q <= 1'b0;
      pin_q     <= 1'b0;
      left      <= '0;
    end else if (fire) begin
      sys_rst_q <= 1'b1;
      pin_q     <= !pin_dis;
      left      <= PW'(LEN - 1);
    end else if (sys_rst_q) begin
      if (left == '0) begin
        sys_rst_q <= 1'b0;
        pin_q     <= 1'b0;
      end else begin
        left <= left - 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_keyed_pkg::*;
#(
  parameter int            AW          = WDT_BUS_W,
  parameter int            DW          = WDT_BUS_W,
  parameter int            CNT_W       = 14,
  parameter int            PULSE_LEN   = 98,
  parameter logic [AW-1:0] KEY_ADDR    = WDT_KEY_ADDR,
  parameter logic [AW-1:0] AUX_ADDR    = WDT_AUX_ADDR,
  parameter logic [DW-1:0] KEY_FIRST   = WDT_KEY_A,
  parameter logic [DW-1:0] KEY_SECOND  = WDT_KEY_B,
  parameter int            PIN_DIS_BIT = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mc_en,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          rst_pin_out,
  output logic          sys_rst_out
);
  logic kick;
  logic pin_dis;
  logic armed;
  logic overflow;
  logic pulse_on;
  logic pin_on;

  wdt_key_decoder #(
    .AW(AW), .DW(DW), .KEY_ADDR(KEY_ADDR), .AUX_ADDR(AUX_ADDR),
    .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND), .PIN_DIS_BIT(PIN_DIS_BIT)
  ) u_dec (
    .clk(clk), .rst(rst), .hold(pulse_on), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .kick(kick), .pin_dis(pin_dis)
  );

  wdt_cycle_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .mc_en(mc_en), .kick(kick),
    .armed(armed), .overflow(overflow)
  );

  wdt_pulse_gen #(.LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst(rst), .fire(overflow), .pin_dis(pin_dis),
    .sys_rst_q(pulse_on), .pin_q(pin_on)
  );

  assign sys_rst_out = pulse_on;
  assign rst_pin_out = pin_on;
endmodule

// File: rtl/wdt_keyed_checker.sv
module wdt_keyed_checker #(
  parameter int LEN = 98
) (
  input logic clk,
  input logic rst,
  input logic armed,
  input logic sys_rst_out,
  input logic rst_pin_out
);
  localparam int HW = $clog2(LEN + 2) + 1;

  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)              hi_cnt <= '0;
    else if (sys_rst_out) hi_cnt <= hi_cnt + 1'b1;
    else                  hi_cnt <= '0;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!sys_rst_out && !rst_pin_out));

  assert_pin_within_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    rst_pin_out |-> sys_rst_out);

  assert_pin_steady_R9: assert property (@(posedge clk) disable iff (rst)
    (sys_rst_out && $past(sys_rst_out)) |-> (rst_pin_out == $past(rst_pin_out)));

  assert_pulse_length_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_rst_out) |-> (hi_cnt == HW'(LEN)));

  assert_pulse_not_long_R8: assert property (@(posedge clk) disable iff (rst)
    sys_rst_out |-> (hi_cnt < HW'(LEN)));

  assert_idle_in_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    sys_rst_out |-> !armed);

  assert_pulse_from_armed_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_out) |-> $past(armed));
endmodule

bind wdt_keyed wdt_keyed_checker #(.LEN(PULSE_LEN)) u_chk (
  .clk(clk), .rst(rst), .armed(armed),
  .sys_rst_out(sys_rst_out), .rst_pin_out(rst_pin_out)
);

// File: tb/tb_wdt_keyed.sv
`timescale 1ns/1ps
module tb_wdt_keyed;
  localparam int OVF = 16384;
  localparam int PLEN = 98;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mc_en = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = 8'h00;
  logic [7:0] wr_data = 8'h00;
  logic       rst_pin_out;
  logic       sys_rst_out;

  int cyc = 0;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdt_keyed dut (
    .clk(clk), .rst(rst), .mc_en(mc_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .rst_pin_out(rst_pin_out), .sys_rst_out(sys_rst_out)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at cyc %0d: actual=%b expected=%b", req, cyc, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_to(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic quiet(input string req, input int n);
    logic seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sys_rst_out || rst_pin_out) seen = 1'b1;
    end
    chk(req, seen, 1'b0);
  endtask

  task automatic hw_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic arm(output int edge_at);
    bus_wr(8'hA6, 8'h1E);
    bus_wr(8'hA6, 8'hE1);
    edge_at = cyc;
  endtask

  // R1: reset state and no pulse without a key
  task automatic t_reset();
    hw_reset();
    chk("R1 sys after reset", sys_rst_out, 1'b0);
    chk("R1 pin after reset", rst_pin_out, 1'b0);
    quiet("R1 no pulse unarmed", 17000);
  endtask

  // R2 R3 R8 R9 R10: arm, overflow edge, pulse length, idle afterwards
  task automatic t_basic();
    int a, e;
    arm(a);
    e = a + OVF;
    wait_to(e - 1);
    chk("R3 before overflow", sys_rst_out, 1'b0);
    wait_to(e);
    chk("R2 R3 overflow edge", sys_rst_out, 1'b1);
    chk("R9 pin follows", rst_pin_out, 1'b1);
    wait_to(e + 10);
    bus_wr(8'hA6, 8'h1E);
    bus_wr(8'hA6, 8'hE1);
    wait_to(e + PLEN - 1);
    chk("R8 last high cycle", sys_rst_out, 1'b1);
    chk("R9 pin last high", rst_pin_out, 1'b1);
    wait_to(e + PLEN);
    chk("R8 pulse ended", sys_rst_out, 1'b0);
    chk("R9 pin ended", rst_pin_out, 1'b0);
    quiet("R10 idle after overflow", 17000);
  endtask

  // R5: restart with a repeated first byte
  task automatic t_restart();
    int a, k;
    arm(a);
    wait_to(a + 10000);
    bus_wr(8'hA6, 8'h1E);
    bus_wr(8'hA6, 8'h1E);
    bus_wr(8'hA6, 8'hE1);
    k = cyc;
    wait_to(k + OVF - 1);
    chk("R5 no overflow before restart window", sys_rst_out, 1'b0);
    wait_to(k + OVF);
    chk("R5 overflow after restart", sys_rst_out, 1'b1);
    wait_to(k + OVF + PLEN);
  endtask

  // R6 R7: broken keys and stray writes do not restart or stop
  task automatic t_broken();
    int a;
    arm(a);
    wait_to(a + 8000);
    bus_wr(8'hA6, 8'h1E);
    bus_wr(8'hA6, 8'h55);
    bus_wr(8'hA6, 8'hE1);
    bus_wr(8'hA6, 8'hE1);
    bus_wr(8'hA7, 8'h1E);
    bus_wr(8'hA6, 8'hE1);
    bus_wr(8'hA6, 8'h00);
    bus_wr(8'h8E, 8'h00);
    wait_to(a + OVF - 1);
    chk("R6 R7 still counting", sys_rst_out, 1'b0);
    wait_to(a + OVF);
    chk("R6 R7 original overflow edge", sys_rst_out, 1'b1);
    wait_to(a + OVF + PLEN);
  endtask

  // R4: machine-cycle enable gates the count
  task automatic t_mcen();
    int a, s;
    @(negedge clk); mc_en = 1'b0;
    arm(a);
    wait_to(a + 5000);
    chk("R4 held while disabled", sys_rst_out, 1'b0);
    mc_en = 1'b1;
    s = cyc;
    wait_to(s + OVF - 1);
    chk("R4 delayed overflow not yet", sys_rst_out, 1'b0);
    wait_to(s + OVF);
    chk("R4 delayed overflow edge", sys_rst_out, 1'b1);
    wait_to(s + OVF + PLEN);
  endtask

  // R9: suppress bit keeps the pin low
  task automatic t_pin_dis();
    int a;
    bus_wr(8'h8E, 8'h08);
    arm(a);
    wait_to(a + OVF);
    chk("R9 internal reset still fires", sys_rst_out, 1'b1);
    chk("R9 pin suppressed", rst_pin_out, 1'b0);
    wait_to(a + OVF + 50);
    chk("R9 pin suppressed mid", rst_pin_out, 1'b0);
    wait_to(a + OVF + PLEN);
    chk("R8 suppressed pulse ends", sys_rst_out, 1'b0);
  endtask

  // R1 R7: only a hardware reset stops an armed watchdog
  task automatic t_hw_stop();
    int a;
    arm(a);
    wait_to(a + 5000);
    hw_reset();
    chk("R1 pin default after reset", rst_pin_out, 1'b0);
    quiet("R1 hardware reset disarms", 17000);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_restart();
    t_broken();
    t_mcen();
    t_pin_dis();
    t_hw_stop();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL timeout (all R): actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule